// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block gives software a way to measure a program's cost in hardware terms. It holds one 32-bit cycle counter and six 32-bit event counters. Each event counter watches one of 256 event pulse lines. An 8-bit type code, written per counter, picks the line it watches. A single global enable gates all counting. Per-counter enable bits are changed through a write-one-to-set register and a write-one-to-clear register. The cycle counter can be slowed by a divide-by-64 prescaler so that it covers longer intervals.

Software reaches the event counters indirectly. It first writes a counter index into a select register. Accesses to the type register and to the count data register then act on that counter. When a counter wraps past its largest value it sets a sticky overflow flag. A per-counter interrupt enable decides which of these flags raise the single interrupt output. A privilege input and a user-access bit decide whether unprivileged accesses reach the registers.

The bus is a single-cycle word interface. A write takes effect at the clock edge where `req_i` and `we_i` are high. Read data is combinational while `req_i` is high and `we_i` is low, and it is 0 when no read is in progress.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset the global enable, all counters, all enables, all overflow flags, the select index and the interrupt output are 0. The control register (word 0) reads 0x3000: the counter count 6 sits in bits 15:11, the divider in bit 3 and the global enable in bit 0.
- R2: While control bit 0 is 0, no counter changes, except through an explicit reset or a data write.
- R3: Word 1 (set) and word 2 (clear) share one mask layout: bit 31 is the cycle counter and bits 5:0 are event counters 0 to 5. Writing 1 to a bit of word 1 enables that counter, and writing 1 to a bit of word 2 disables it. Zero bits have no effect. Reading either word returns the current mask.
- R4: With divider 0, an enabled cycle counter (word 6) advances by one on every clock edge at which control bit 0 and mask bit 31 are both 1.
- R5: With control bit 3 set, the cycle counter advances once every 64 qualifying edges. A cycle-counter reset restarts the prescaler.
- R6: Writing control bit 1 as 1 zeroes all event counters. Writing control bit 2 as 1 zeroes the cycle counter only. Both bits read as 0. A reset wins over an increment in the same cycle.
- R7: Word 3 holds the select index. Word 4 reads and writes the 8-bit type code of the selected counter. Event counter i advances on each enabled edge at which `events_i[type_i]` is high.
- R8: With a select index of 6 or 7, reads of words 4 and 5 return 0 and writes to them change no counter or type code.
- R9: A counter that wraps from 0xFFFFFFFF to 0 sets its sticky flag in word 7, using the same bit layout as R3. Writing 1 to a flag clears it, and a new wrap wins over a clear in the same cycle.
- R10: `irq_o` is high exactly when some overflow flag is set and its bit in the interrupt enable register (word 8, same layout as R3) is 1.
- R11: With `priv_i` low and the user-access bit (word 9, bit 0) at 0, reads of every other word return 0 and writes to them are ignored. Word 9 is writable only with `priv_i` high, and it is readable in either mode.
- R12: Writing word 5 loads the selected event counter, and writing word 6 loads the cycle counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write (1) or read (0) |
| priv_i | input | 1 | Access is privileged |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| events_i | input | 256 | Event pulse lines, one per type code |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Assertions watch the following properties on every cycle:
- a counter reset always lands at zero, even against a same-cycle increment;
- the cycle counter holds still while the global enable is off;
- a wrap always leaves its sticky flag set;
- the interrupt never drops without a bus write;
- blocked user reads and out-of-range selected reads return zero;
- enable set and clear writes reach the mask.

Other behaviours only the directed scenarios can show:
- exact counts across a window, including the 127 and 128 edge boundaries of the divide-by-64 prescaler;
- routing of a chosen event line to the right counter while the other lines are ignored;
- ignored writes that leave state untouched, which the bench reads back through the bus.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned ADDR_W        = 4;
  localparam int unsigned CYC_BIT       = 31;
  localparam int unsigned NUM_FIELD_LSB = 11;
  localparam int unsigned NUM_FIELD_W   = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL     = 4'd0,
    REG_EN_SET   = 4'd1,
    REG_EN_CLR   = 4'd2,
    REG_SEL      = 4'd3,
    REG_EVT_TYPE = 4'd4,
    REG_EVT_CNT  = 4'd5,
    REG_CYC_CNT  = 4'd6,
    REG_OVF      = 4'd7,
    REG_IRQ_EN   = 4'd8,
    REG_USER     = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] value_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  // priority: reset, then load, then increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign value_o = cnt_q;
  assign wrap_o  = inc_i & ~clr_i & ~wr_i & (&cnt_q);

  assert_clear_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (value_o == '0));
  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !wr_i && !inc_i) |=> $stable(value_o));
endmodule

// File: rtl/pm_prescaler.sv
module pm_prescaler #(
  parameter int unsigned PRESC_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  logic [PRESC_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else if (run_i) div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i & (&div_q);

  assert_tick_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !clr_i) |=> (div_q == '0));
  assert_clr_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tick_o || (PRESC_W == 0));
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import perf_mon_pkg::*;
#(
  parameter int unsigned NUM_EVT = 6,
  parameter int unsigned TYPE_W  = 8,
  parameter int unsigned PRESC_W = 6,
  localparam int unsigned EVT_LINES = 1 << TYPE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic                 priv_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [EVT_LINES-1:0] events_i,
  output logic                 irq_o
);
  localparam int unsigned SEL_W = $clog2(NUM_EVT + 1);

  logic               ctrl_en_q, ctrl_div_q, user_en_q;
  logic               cyc_en_q, ovf_cyc_q, irq_cyc_q;
  logic [NUM_EVT-1:0] evt_en_q, ovf_evt_q, irq_evt_q;
  logic [SEL_W-1:0]   sel_q;

  logic               access_ok, bus_wr, bus_rd;
  logic               wr_ctrl, wr_set, wr_clr, wr_sel, wr_type, wr_evcnt;
  logic               wr_cyc, wr_ovf, wr_irq, wr_user;
  logic               cyc_clr, evt_clr;
  logic               cyc_tick, cyc_inc, cyc_wrap;
  logic [DATA_W-1:0]  cyc_cnt;
  logic [NUM_EVT-1:0] evt_wrap;
  logic [DATA_W-1:0]  evt_cnt  [NUM_EVT];
  logic [TYPE_W-1:0]  evt_type [NUM_EVT];
  logic [DATA_W-1:0]  sel_cnt;
  logic [TYPE_W-1:0]  sel_type;
  logic [DATA_W-1:0]  en_mask, ovf_mask, irq_mask;

  // access decode
  assign access_ok = priv_i | user_en_q;
  assign bus_wr    = req_i & we_i & access_ok;
  assign bus_rd    = req_i & ~we_i;

  assign wr_ctrl  = bus_wr & (addr_i == REG_CTRL);
  assign wr_set   = bus_wr & (addr_i == REG_EN_SET);
  assign wr_clr   = bus_wr & (addr_i == REG_EN_CLR);
  assign wr_sel   = bus_wr & (addr_i == REG_SEL);
  assign wr_type  = bus_wr & (addr_i == REG_EVT_TYPE);
  assign wr_evcnt = bus_wr & (addr_i == REG_EVT_CNT);
  assign wr_cyc   = bus_wr & (addr_i == REG_CYC_CNT);
  assign wr_ovf   = bus_wr & (addr_i == REG_OVF);
  assign wr_irq   = bus_wr & (addr_i == REG_IRQ_EN);
  assign wr_user  = req_i & we_i & priv_i & (addr_i == REG_USER);

  assign evt_clr = wr_ctrl & wdata_i[1];
  assign cyc_clr = wr_ctrl & wdata_i[2];

  // control and mask state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q  <= 1'b0;
      ctrl_div_q <= 1'b0;
      user_en_q  <= 1'b0;
      cyc_en_q   <= 1'b0;
      evt_en_q   <= '0;
      ovf_cyc_q  <= 1'b0;
      ovf_evt_q  <= '0;
      irq_cyc_q  <= 1'b0;
      irq_evt_q  <= '0;
      sel_q      <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en_q  <= wdata_i[0];
        ctrl_div_q <= wdata_i[3];
      end
      cyc_en_q <= (cyc_en_q | (wr_set & wdata_i[CYC_BIT])) & ~(wr_clr & wdata_i[CYC_BIT]);
      evt_en_q <= (evt_en_q | ({NUM_EVT{wr_set}} & wdata_i[NUM_EVT-1:0]))
                & ~({NUM_EVT{wr_clr}} & wdata_i[NUM_EVT-1:0]);
      if (wr_sel) sel_q <= wdata_i[SEL_W-1:0];
      // a new wrap beats a same-cycle clear
      ovf_cyc_q <= cyc_wrap | (ovf_cyc_q & ~(wr_ovf & wdata_i[CYC_BIT]));
      ovf_evt_q <= evt_wrap | (ovf_evt_q & ~({NUM_EVT{wr_ovf}} & wdata_i[NUM_EVT-1:0]));
      if (wr_irq) begin
        irq_cyc_q <= wdata_i[CYC_BIT];
        irq_evt_q <= wdata_i[NUM_EVT-1:0];
      end
      if (wr_user) user_en_q <= wdata_i[0];
    end
  end

  // cycle counter path
  pm_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cyc_clr),
    .run_i  (ctrl_en_q & cyc_en_q & ctrl_div_q),
    .tick_o (cyc_tick)
  );

  assign cyc_inc = ctrl_en_q & cyc_en_q & (ctrl_div_q ? cyc_tick : 1'b1);

  pm_counter #(.W(DATA_W)) u_cyc_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cyc_clr),
    .wr_i    (wr_cyc),
    .wdata_i (wdata_i),
    .inc_i   (cyc_inc),
    .value_o (cyc_cnt),
    .wrap_o  (cyc_wrap)
  );

  // event counters
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    logic              is_sel;
    logic [TYPE_W-1:0] type_q;
    logic              hit;

    assign is_sel = (sel_q == SEL_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                type_q <= '0;
      else if (wr_type && is_sel) type_q <= wdata_i[TYPE_W-1:0];
    end

    assign hit         = events_i[type_q];
    assign evt_type[i] = type_q;

    pm_counter #(.W(DATA_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (evt_clr),
      .wr_i    (wr_evcnt & is_sel),
      .wdata_i (wdata_i),
      .inc_i   (ctrl_en_q & evt_en_q[i] & hit),
      .value_o (evt_cnt[i]),
      .wrap_o  (evt_wrap[i])
    );
  end

  // indirect lookup; an out-of-range index matches nothing
  always_comb begin
    sel_cnt  = '0;
    sel_type = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (sel_q == SEL_W'(i)) begin
        sel_cnt  = evt_cnt[i];
        sel_type = evt_type[i];
      end
    end
  end

  always_comb begin
    en_mask  = '0;
    ovf_mask = '0;
    irq_mask = '0;
    en_mask[CYC_BIT]       = cyc_en_q;
    en_mask[NUM_EVT-1:0]   = evt_en_q;
    ovf_mask[CYC_BIT]      = ovf_cyc_q;
    ovf_mask[NUM_EVT-1:0]  = ovf_evt_q;
    irq_mask[CYC_BIT]      = irq_cyc_q;
    irq_mask[NUM_EVT-1:0]  = irq_evt_q;
  end

  assign irq_o = |(ovf_mask & irq_mask);

  // read mux
  always_comb begin
    rdata_o = '0;
    if (bus_rd) begin
      if (addr_i == REG_USER) begin
        rdata_o[0] = user_en_q;
      end else if (access_ok) begin
        case (addr_i)
          REG_CTRL: begin
            rdata_o[0] = ctrl_en_q;
            rdata_o[3] = ctrl_div_q;
            rdata_o[NUM_FIELD_LSB +: NUM_FIELD_W] = NUM_FIELD_W'(NUM_EVT);
          end
          REG_EN_SET, REG_EN_CLR: rdata_o = en_mask;
          REG_SEL:      rdata_o[SEL_W-1:0]  = sel_q;
          REG_EVT_TYPE: rdata_o[TYPE_W-1:0] = sel_type;
          REG_EVT_CNT:  rdata_o = sel_cnt;
          REG_CYC_CNT:  rdata_o = cyc_cnt;
          REG_OVF:      rdata_o = ovf_mask;
          REG_IRQ_EN:   rdata_o = irq_mask;
          default:      rdata_o = '0;
        endcase
      end
    end
  end

  assert_gate_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_en_q && !cyc_clr && !wr_cyc) |=> $stable(cyc_cnt));
  assert_en_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && access_ok && addr_i == REG_EN_SET && wdata_i[CYC_BIT]) |=> cyc_en_q);
  assert_en_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && access_ok && addr_i == REG_EN_CLR && wdata_i[CYC_BIT]) |=> !cyc_en_q);
  assert_sel_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && sel_q >= SEL_W'(NUM_EVT) &&
     (addr_i == REG_EVT_TYPE || addr_i == REG_EVT_CNT)) |-> (rdata_o == '0));
  assert_wrap_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_wrap |=> ovf_cyc_q);
  assert_irq_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(req_i && we_i)) |=> irq_o);
  assert_user_block_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !priv_i && !user_en_q && addr_i != REG_USER) |-> (rdata_o == '0));
endmodule

// File: tb/test_perf_mon_unit.sv
module test_perf_mon_unit;
  import perf_mon_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, priv = 1'b1;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [255:0] events = '0;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  perf_mon_unit i_perf_mon_unit (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .priv_i(priv),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .events_i(events), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    expect_rd("R1 ctrl", REG_CTRL, 32'h0000_3000);
    expect_rd("R1 mask", REG_EN_SET, 32'h0);
    expect_rd("R1 cycle", REG_CYC_CNT, 32'h0);
    expect_rd("R1 event0", REG_EVT_CNT, 32'h0);
    expect_rd("R1 ovf", REG_OVF, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask;
    bus_wr(REG_EN_SET, 32'h8000_0005);
    expect_rd("R3 set", REG_EN_SET, 32'h8000_0005);
    expect_rd("R3 clr view", REG_EN_CLR, 32'h8000_0005);
    bus_wr(REG_EN_SET, 32'h0000_0002);
    expect_rd("R3 set accumulates", REG_EN_SET, 32'h8000_0007);
    bus_wr(REG_EN_SET, 32'h0);
    expect_rd("R3 zero no effect", REG_EN_SET, 32'h8000_0007);
    bus_wr(REG_EN_CLR, 32'h8000_0001);
    expect_rd("R3 clear", REG_EN_SET, 32'h0000_0006);
    bus_wr(REG_EN_CLR, 32'h0000_003F);
    expect_rd("R3 clear all", REG_EN_SET, 32'h0);
  endtask

  task automatic t_gate;
    bus_wr(REG_EN_SET, 32'h8000_0000);
    repeat (20) @(negedge clk);
    expect_rd("R2 gated", REG_CYC_CNT, 32'h0);
  endtask

  task automatic t_cycle;
    bus_wr(REG_CTRL, 32'h5);
    repeat (10) @(negedge clk);
    bus_wr(REG_CTRL, 32'h0);
    expect_rd("R4 count", REG_CYC_CNT, 32'd11);
    expect_rd("R6 reset bits read 0", REG_CTRL, 32'h0000_3000);
  endtask

  task automatic t_priority;
    bus_wr(REG_CTRL, 32'h1);
    repeat (5) @(negedge clk);
    bus_wr(REG_CTRL, 32'h5);
    expect_rd("R6 reset beats inc", REG_CYC_CNT, 32'h0);
    expect_rd("R6 ctrl readback", REG_CTRL, 32'h0000_3001);
    bus_wr(REG_CTRL, 32'h0);
  endtask

  task automatic t_div;
    bus_wr(REG_CTRL, 32'hC);
    bus_wr(REG_CTRL, 32'h9);
    repeat (126) @(negedge clk);
    bus_wr(REG_CTRL, 32'h0);
    expect_rd("R5 127 edges", REG_CYC_CNT, 32'd1);
    bus_wr(REG_CTRL, 32'hC);
    bus_wr(REG_CTRL, 32'h9);
    repeat (127) @(negedge clk);
    bus_wr(REG_CTRL, 32'h0);
    expect_rd("R5 128 edges", REG_CYC_CNT, 32'd2);
  endtask

  task automatic t_events;
    bus_wr(REG_EN_CLR, 32'h8000_0000);
    bus_wr(REG_EN_SET, 32'h3);
    bus_wr(REG_SEL, 32'd0);
    bus_wr(REG_EVT_TYPE, 32'h72);
    bus_wr(REG_SEL, 32'd1);
    bus_wr(REG_EVT_TYPE, 32'h09);
    expect_rd("R7 type readback", REG_EVT_TYPE, 32'h09);
    events[8'h72] = 1'b1;
    bus_wr(REG_CTRL, 32'h3);
    repeat (9) @(negedge clk);
    bus_wr(REG_CTRL, 32'h0);
    events[8'h72] = 1'b0;
    expect_rd("R7 other line ignored", REG_EVT_CNT, 32'd0);
    bus_wr(REG_CTRL, 32'h1);
    for (int k = 0; k < 3; k++) begin
      events[8'h09] = 1'b1;
      @(negedge clk);
      events[8'h09] = 1'b0;
      @(negedge clk);
    end
    bus_wr(REG_CTRL, 32'h0);
    expect_rd("R7 pulses counted", REG_EVT_CNT, 32'd3);
    bus_wr(REG_SEL, 32'd0);
    expect_rd("R7 level counted", REG_EVT_CNT, 32'd10);
    bus_wr(REG_CTRL, 32'h2);
    expect_rd("R6 event reset", REG_EVT_CNT, 32'd0);
    expect_rd("R6 cycle untouched", REG_CYC_CNT, 32'd2);
  endtask

  task automatic t_sel_range;
    bus_wr(REG_SEL, 32'd6);
    expect_rd("R8 type read", REG_EVT_TYPE, 32'h0);
    expect_rd("R8 count read", REG_EVT_CNT, 32'h0);
    bus_wr(REG_EVT_CNT, 32'h1234);
    bus_wr(REG_EVT_TYPE, 32'h55);
    bus_wr(REG_SEL, 32'd7);
    expect_rd("R8 index 7", REG_EVT_CNT, 32'h0);
    for (int i = 0; i < 6; i++) begin
      bus_wr(REG_SEL, i);
      expect_rd($sformatf("R8 counter %0d untouched", i), REG_EVT_CNT, 32'h0);
      expect_rd($sformatf("R8 type %0d untouched", i), REG_EVT_TYPE,
                (i == 0) ? 32'h72 : (i == 1) ? 32'h09 : 32'h0);
    end
  endtask

  task automatic t_overflow;
    bus_wr(REG_EN_CLR, 32'h3F);
    bus_wr(REG_EN_SET, 32'h8000_0000);
    bus_wr(REG_CYC_CNT, 32'hFFFF_FFFD);
    expect_rd("R12 cycle load", REG_CYC_CNT, 32'hFFFF_FFFD);
    bus_wr(REG_IRQ_EN, 32'h8000_0000);
    bus_wr(REG_CTRL, 32'h1);
    repeat (2) @(negedge clk);
    check("R10 no irq before wrap", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R10 irq on wrap", {31'b0, irq}, 32'h1);
    bus_wr(REG_CTRL, 32'h0);
    expect_rd("R9 cycle flag", REG_OVF, 32'h8000_0000);
    expect_rd("R9 wrapped value", REG_CYC_CNT, 32'd1);
    bus_wr(REG_OVF, 32'h8000_0000);
    expect_rd("R9 w1c", REG_OVF, 32'h0);
    check("R10 irq cleared", {31'b0, irq}, 32'h0);
    bus_wr(REG_EN_CLR, 32'h8000_0000);
    bus_wr(REG_EN_SET, 32'h1);
    bus_wr(REG_SEL, 32'd0);
    bus_wr(REG_EVT_CNT, 32'hFFFF_FFFF);
    events[8'h72] = 1'b1;
    bus_wr(REG_CTRL, 32'h1);
    bus_wr(REG_CTRL, 32'h0);
    events[8'h72] = 1'b0;
    expect_rd("R9 event flag", REG_OVF, 32'h1);
    expect_rd("R12 event wrapped", REG_EVT_CNT, 32'h0);
    check("R10 masked irq", {31'b0, irq}, 32'h0);
    bus_wr(REG_IRQ_EN, 32'h8000_0001);
    check("R10 unmasked irq", {31'b0, irq}, 32'h1);
    bus_wr(REG_OVF, 32'h1);
    check("R10 irq after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_user;
    priv = 1'b0;
    expect_rd("R11 blocked read", REG_CTRL, 32'h0);
    bus_wr(REG_EN_SET, 32'h10);
    bus_wr(REG_USER, 32'h1);
    expect_rd("R11 user bit readable", REG_USER, 32'h0);
    priv = 1'b1;
    expect_rd("R11 write ignored", REG_EN_SET, 32'h1);
    bus_wr(REG_USER, 32'h1);
    priv = 1'b0;
    expect_rd("R11 user read allowed", REG_EN_SET, 32'h1);
    bus_wr(REG_EN_SET, 32'h10);
    expect_rd("R11 user write allowed", REG_EN_SET, 32'h11);
    bus_wr(REG_USER, 32'h0);
    expect_rd("R11 user cannot clear bit", REG_USER, 32'h1);
    priv = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_gate();
    t_cycle();
    t_priority();
    t_div();
    t_events();
    t_sel_range();
    t_overflow();
    t_user();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule